// File: doc/BRIEF.md
# Framed Byte-Command Bus Engine

This block turns a stream of command bytes into accesses on a simple 32-bit register bus. It then answers each command with a stream of response bytes. A host places a framed command on the byte input. The block buffers the bytes in a small receive queue and parses the frame. It then does one of three things: holds the core in reset for a fixed number of cycles, performs one read, or performs one write. When the operation is done, it sends back a framed response carrying a status code and, after a successful read, the data that was read.

Both byte interfaces use valid/ready. A byte moves only on a clock edge where both valid and ready are high. The sender must hold valid and the byte stable until that edge.

- **Input side.** The block lowers `rx_ready` only when its receive queue is full. The queue stops being drained while a command runs or while its response is still being sent.
- **Output side.** The consumer may hold `tx_ready` low for any number of cycles. The block then keeps the current response byte on `tx_data` with `tx_valid` high.

The core side is a plain single-cycle bus. The core must return `core_rdata` and `core_err` combinationally in the same cycle that `core_sel` is high.

Top module: `bytecmd_engine`

## Requirements
- R1: After reset, `tx_valid` and `core_sel` are low, `core_rst_n` is high and `rx_ready` is high.
- R2: The read frame is 0x55, 0x10, address high byte, address low byte, 0xAA. It causes exactly one bus cycle with `core_sel`=1, `core_wr`=0 and that address. If `core_err` is low, the response is 0xAA, 0x7F, four read-data bytes (most significant first), 0x55.
- R3: The write frame is 0x55, 0x11, two address bytes (high first), four data bytes (most significant first), 0xAA. It causes exactly one bus cycle with `core_sel`=1, `core_wr`=1, that address and that data. If `core_err` is low, the response is 0xAA, 0x7E, 0x55.
- R4: The reset frame is 0x55, 0x01, 0xAA. It drives `core_rst_n` low for exactly RST_CYCLES cycles (default 4) with no bus cycle, then responds 0xAA, 0x7D, 0x55.
- R5: If `core_err` is high during a read or write bus cycle, the response is 0xAA, 0xFD, 0x55, and no data bytes are sent.
- R6: If the byte where 0xAA is expected holds any other value, the frame is dropped with no bus cycle and no reset, and the response is 0xAA, 0xFD, 0x55.
- R7: An opcode byte other than 0x01, 0x10 or 0x11 is answered at once with 0xAA, 0xFE, 0x55, with no bus cycle. The parser then waits for a new 0x55.
- R8: While the parser is waiting for a frame, any byte other than 0x55 is consumed and ignored. It produces no response and no bus cycle.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R10: With the response stalled, the block accepts at most DEPTH bytes (default 4) and then holds `rx_ready` low. Every accepted byte is processed later in order, and none is lost.
- R11: `core_wr` is high only together with `core_sel`, and `core_sel` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Command byte offered |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | 8 | Command byte |
| tx_valid | output | 1 | Response byte offered |
| tx_ready | input | 1 | Consumer takes response byte |
| tx_data | output | 8 | Response byte |
| core_rst_n | output | 1 | Active-low reset to the core |
| core_sel | output | 1 | Bus cycle strobe |
| core_wr | output | 1 | Bus cycle is a write |
| core_addr | output | 16 | Bus address |
| core_wdata | output | 32 | Bus write data |
| core_rdata | input | 32 | Bus read data, valid while `core_sel` is high |
| core_err | input | 1 | Bus error, valid while `core_sel` is high |

## Verification
The engine is driven with a random mix of well-formed reads, writes and resets, frames with unknown opcodes, and frames with a corrupted end byte. Response bytes and bus cycles are compared against a shadow copy of the core memory.

- Addresses above the model's 256 words separate the error status from the OK status.
- Back-to-back writes followed by reads of the same word show that address and data bytes are assembled in the right order.
- Stray bytes between frames show that the parser resynchronises only on the start byte.
- A directed run keeps `tx_ready` low while a following frame arrives. This separates correct receive back-pressure from lost bytes.
- Random `tx_ready` gaps throughout show that output bytes are held under stall.

// File: rtl/bce_pkg.sv
package bce_pkg;
  localparam logic [7:0] CMD_SOF   = 8'h55;
  localparam logic [7:0] CMD_EOF   = 8'hAA;
  localparam logic [7:0] OP_RST    = 8'h01;
  localparam logic [7:0] OP_RD     = 8'h10;
  localparam logic [7:0] OP_WR     = 8'h11;
  localparam logic [7:0] RSP_SOF   = 8'hAA;
  localparam logic [7:0] RSP_EOF   = 8'h55;
  localparam logic [7:0] ST_RD_OK  = 8'h7F;
  localparam logic [7:0] ST_WR_OK  = 8'h7E;
  localparam logic [7:0] ST_RST_OK = 8'h7D;
  localparam logic [7:0] ST_ERR    = 8'hFD;
  localparam logic [7:0] ST_UNK    = 8'hFE;

  typedef enum logic [3:0] {
    P_IDLE, P_OPC, P_ADDR, P_DATA, P_END, P_RST, P_RD, P_WR, P_RESP
  } pstate_t;
endpackage

// File: rtl/bce_rx_fifo.sv
module bce_rx_fifo #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       pop,
  output logic       nonempty,
  output logic [7:0] head
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, take;

  assign in_ready = (cnt != FULL);
  assign push     = in_valid && in_ready;
  assign take     = pop && nonempty;
  assign nonempty = (cnt != '0);
  assign head     = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (take) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      if (push && !take)      cnt <= cnt + 1'b1;
      else if (take && !push) cnt <= cnt - 1'b1;
    end
  end

  AST_FIFO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !take) |=> (cnt == $past(cnt) + 1'b1)); // R10
  AST_FIFO_POP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty); // R10
endmodule

// File: rtl/bce_tx_framer.sv
module bce_tx_framer #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [7:0]    ld_status,
  input  logic          ld_with_data,
  input  logic [8*NB-1:0] ld_data,
  output logic          busy,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data
);
  import bce_pkg::*;
  localparam int IW = $clog2(NB + 3);

  logic [IW-1:0]   idx, last_idx;
  logic [7:0]      status_r;
  logic            wd_r;
  logic [8*NB-1:0] data_r;
  logic            fire;

  assign tx_valid = busy;
  assign fire     = busy && tx_ready;
  assign last_idx = wd_r ? IW'(NB + 2) : IW'(2);

  always_comb begin
    if (idx == '0)                tx_data = RSP_SOF;
    else if (idx == IW'(1))       tx_data = status_r;
    else if (idx == last_idx)     tx_data = RSP_EOF;
    else                          tx_data = data_r[8*NB-1 -: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      status_r <= '0;
      wd_r     <= 1'b0;
      data_r   <= '0;
    end else if (!busy) begin
      if (ld) begin
        busy     <= 1'b1;
        idx      <= '0;
        status_r <= ld_status;
        wd_r     <= ld_with_data;
        data_r   <= ld_data;
      end
    end else if (fire) begin
      if (idx == last_idx) begin
        busy <= 1'b0;
      end else begin
        idx <= idx + 1'b1;
        if (idx >= IW'(2)) data_r <= data_r << 8;
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R9
  AST_FRAME_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> (tx_data == RSP_SOF)); // R2
endmodule

// File: rtl/bytecmd_engine.sv
module bytecmd_engine #(
  parameter int DEPTH      = 4,
  parameter int RST_CYCLES = 4,
  parameter int ADDR_BYTES = 2,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  output logic                    rx_ready,
  input  logic [7:0]              rx_data,
  output logic                    tx_valid,
  input  logic                    tx_ready,
  output logic [7:0]              tx_data,
  output logic                    core_rst_n,
  output logic                    core_sel,
  output logic                    core_wr,
  output logic [8*ADDR_BYTES-1:0] core_addr,
  output logic [8*DATA_BYTES-1:0] core_wdata,
  input  logic [8*DATA_BYTES-1:0] core_rdata,
  input  logic                    core_err
);
  import bce_pkg::*;
  localparam int AWD = 8 * ADDR_BYTES;
  localparam int DWD = 8 * DATA_BYTES;
  localparam int CNW = $clog2(RST_CYCLES + ADDR_BYTES + DATA_BYTES + 1);

  pstate_t        st, st_n;
  logic [7:0]     opc, opc_n;
  logic [AWD-1:0] addr_r, addr_n;
  logic [DWD-1:0] wdat_r, wdat_n;
  logic [CNW-1:0] cnt, cnt_n;

  logic           pop, have, busy;
  logic [7:0]     b;
  logic           ld, ld_wd;
  logic [7:0]     ld_st;
  logic [DWD-1:0] ld_dat;

  bce_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .in_valid(rx_valid), .in_ready(rx_ready),
    .in_data(rx_data), .pop(pop), .nonempty(have), .head(b)
  );

  bce_tx_framer #(.NB(DATA_BYTES)) u_framer (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_status(ld_st),
    .ld_with_data(ld_wd), .ld_data(ld_dat), .busy(busy),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  assign core_sel   = (st == P_RD) || (st == P_WR);
  assign core_wr    = (st == P_WR);
  assign core_rst_n = (st != P_RST);
  assign core_addr  = addr_r;
  assign core_wdata = wdat_r;

  always_comb begin
    st_n   = st;
    opc_n  = opc;
    addr_n = addr_r;
    wdat_n = wdat_r;
    cnt_n  = cnt;
    ld     = 1'b0;
    ld_st  = ST_ERR;
    ld_wd  = 1'b0;
    ld_dat = '0;
    pop    = 1'b0;
    case (st)
      P_IDLE: if (have) begin
        pop = 1'b1;
        if (b == CMD_SOF) st_n = P_OPC;
      end
      P_OPC: if (have) begin
        pop   = 1'b1;
        opc_n = b;
        cnt_n = '0;
        if (b == OP_RST)                    st_n = P_END;
        else if (b == OP_RD || b == OP_WR)  st_n = P_ADDR;
        else begin
          ld    = 1'b1;
          ld_st = ST_UNK;
          st_n  = P_RESP;
        end
      end
      P_ADDR: if (have) begin
        pop    = 1'b1;
        addr_n = {addr_r[AWD-9:0], b};
        if (cnt == CNW'(ADDR_BYTES - 1)) begin
          cnt_n = '0;
          st_n  = (opc == OP_WR) ? P_DATA : P_END;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      P_DATA: if (have) begin
        pop    = 1'b1;
        wdat_n = {wdat_r[DWD-9:0], b};
        if (cnt == CNW'(DATA_BYTES - 1)) begin
          cnt_n = '0;
          st_n  = P_END;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      P_END: if (have) begin
        pop   = 1'b1;
        cnt_n = '0;
        if (b != CMD_EOF) begin
          ld    = 1'b1;
          ld_st = ST_ERR;
          st_n  = P_RESP;
        end else if (opc == OP_RST) st_n = P_RST;
        else if (opc == OP_RD)      st_n = P_RD;
        else                        st_n = P_WR;
      end
      P_RST: begin
        cnt_n = cnt + 1'b1;
        if (cnt == CNW'(RST_CYCLES - 1)) begin
          ld    = 1'b1;
          ld_st = ST_RST_OK;
          st_n  = P_RESP;
        end
      end
      P_RD: begin
        ld     = 1'b1;
        ld_st  = core_err ? ST_ERR : ST_RD_OK;
        ld_wd  = !core_err;
        ld_dat = core_rdata;
        st_n   = P_RESP;
      end
      P_WR: begin
        ld    = 1'b1;
        ld_st = core_err ? ST_ERR : ST_WR_OK;
        st_n  = P_RESP;
      end
      P_RESP: if (!busy) st_n = P_IDLE;
      default: st_n = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= P_IDLE;
      opc    <= '0;
      addr_r <= '0;
      wdat_r <= '0;
      cnt    <= '0;
    end else begin
      st     <= st_n;
      opc    <= opc_n;
      addr_r <= addr_n;
      wdat_r <= wdat_n;
      cnt    <= cnt_n;
    end
  end

  AST_SEL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_sel |=> !core_sel); // R11
  AST_WR_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |-> core_sel); // R11
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !core_rst_n |-> (!core_sel && !tx_valid)); // R4
  AST_ACCESS_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    core_sel |=> tx_valid); // R3
endmodule

// File: tb/sim_bytecmd_engine.sv
module sim_bytecmd_engine;
  localparam int RSTC = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        core_rst_n, core_sel, core_wr, core_err;
  logic [15:0] core_addr;
  logic [31:0] core_wdata, core_rdata;

  bytecmd_engine #(.DEPTH(4), .RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .core_rst_n(core_rst_n), .core_sel(core_sel),
    .core_wr(core_wr), .core_addr(core_addr), .core_wdata(core_wdata),
    .core_rdata(core_rdata), .core_err(core_err)
  );

  // core model: 256 words, error above
  logic [31:0] cmem [256];
  assign core_rdata = cmem[core_addr[7:0]];
  assign core_err   = core_sel && (core_addr >= 16'd256);
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) cmem[i] <= {4{i[7:0]}};
    end else if (core_sel && core_wr && core_addr < 16'd256) begin
      cmem[core_addr[7:0]] <= core_wdata;
    end
  end

  logic [31:0] sh [256];
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] got[$];
  logic [7:0] exp_q[$];
  int acc_n, rst_low, hold_bad = 0;
  logic acc_wr;
  logic [15:0] acc_addr;
  logic [31:0] acc_wd;
  bit stall_tx = 1'b0;
  logic pv = 1'b0, pr = 1'b0;
  logic [7:0] pd = '0;

  // output consumer and monitors, all at the falling edge
  always @(negedge clk) begin
    logic r;
    if (pv && !pr && !(tx_valid && tx_data == pd)) hold_bad++;
    r = stall_tx ? 1'b0 : (($urandom % 4) != 0);
    if (tx_valid && r) got.push_back(tx_data);
    tx_ready = r;
    pv = tx_valid; pr = r; pd = tx_data;
    if (core_sel) begin
      acc_n++; acc_wr = core_wr; acc_addr = core_addr; acc_wd = core_wdata;
    end
    if (rst_n && !core_rst_n) rst_low++;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    repeat ($urandom % 3) @(negedge clk);
    rx_data  = v;
    rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic clear_logs();
    got.delete(); exp_q.delete(); acc_n = 0; rst_low = 0;
  endtask

  task automatic wait_resp(input int n);
    int t = 0;
    while (got.size() < n && t < 4000) begin @(negedge clk); t++; end
    repeat (12) @(negedge clk);
  endtask

  task automatic cmp_stream(input string req);
    int bad = 0;
    chk(got.size() == exp_q.size(), req, "response length", got.size(), exp_q.size());
    foreach (exp_q[i])
      if (i < got.size() && got[i] !== exp_q[i]) begin
        bad++;
        $display("FAIL %s byte %0d: actual=%0h expected=%0h", req, i, got[i], exp_q[i]);
      end
    n_chk++;
    if (bad != 0) n_fail++;
  endtask

  // kind: 0 read, 1 write, 2 reset, 3 unknown opcode, 4 bad end byte
  task automatic do_cmd(input int kind, input logic [15:0] a, input logic [31:0] d,
                        input logic [7:0] x);
    logic [7:0] fb[$];
    string req;
    int ex_acc = 0, ex_rst = 0;
    logic ex_wr = 1'b0;
    clear_logs();
    case (kind)
      0: begin
        fb = {8'h55, 8'h10, a[15:8], a[7:0], 8'hAA};
        ex_acc = 1;
        if (a < 16'd256) begin
          req = "R2";
          exp_q = {8'hAA, 8'h7F, sh[a[7:0]][31:24], sh[a[7:0]][23:16],
                   sh[a[7:0]][15:8], sh[a[7:0]][7:0], 8'h55};
        end else begin
          req = "R5"; exp_q = {8'hAA, 8'hFD, 8'h55};
        end
      end
      1: begin
        fb = {8'h55, 8'h11, a[15:8], a[7:0], d[31:24], d[23:16], d[15:8], d[7:0], 8'hAA};
        ex_acc = 1; ex_wr = 1'b1;
        if (a < 16'd256) begin
          req = "R3"; exp_q = {8'hAA, 8'h7E, 8'h55}; sh[a[7:0]] = d;
        end else begin
          req = "R5"; exp_q = {8'hAA, 8'hFD, 8'h55};
        end
      end
      2: begin
        req = "R4"; fb = {8'h55, 8'h01, 8'hAA};
        exp_q = {8'hAA, 8'h7D, 8'h55}; ex_rst = RSTC;
      end
      3: begin
        req = "R7"; fb = {8'h55, x};
        exp_q = {8'hAA, 8'hFE, 8'h55};
      end
      default: begin
        req = "R6"; fb = {8'h55, 8'h10, a[15:8], a[7:0], x};
        exp_q = {8'hAA, 8'hFD, 8'h55};
      end
    endcase
    foreach (fb[i]) send_byte(fb[i]);
    wait_resp(exp_q.size());
    cmp_stream(req);
    chk(acc_n == ex_acc, req, "bus cycles", acc_n, ex_acc);
    chk(rst_low == ex_rst, req, "reset cycles", rst_low, ex_rst);
    if (ex_acc == 1 && acc_n == 1) begin
      chk(acc_addr == a && acc_wr == ex_wr, req, "bus addr/dir",
          {acc_wr, acc_addr}, {ex_wr, a});
      if (ex_wr) chk(acc_wd == d, req, "bus wdata", acc_wd, d);
    end
  endtask

  initial begin
    logic [7:0] op;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 256; i++) sh[i] = {4{i[7:0]}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!tx_valid && !core_sel && core_rst_n && rx_ready, "R1", "idle outputs",
        {tx_valid, core_sel, core_rst_n, rx_ready}, 4'b0011);

    // directed cases
    do_cmd(0, 16'h0023, '0, '0);            // R2
    do_cmd(1, 16'h00AA, 32'h1337BEEF, '0);  // R3
    do_cmd(0, 16'h00AA, '0, '0);            // R2 read-back
    do_cmd(0, 16'h0200, '0, '0);            // R5 read error
    do_cmd(1, 16'h0300, 32'hDEADBEEF, '0);  // R5 write error
    do_cmd(2, '0, '0, '0);                  // R4
    do_cmd(3, '0, '0, 8'h33);               // R7
    do_cmd(4, 16'h0005, '0, 8'h77);         // R6

    // R8 stray bytes while idle
    clear_logs();
    send_byte(8'h12); send_byte(8'hAA); send_byte(8'h00);
    repeat (30) @(negedge clk);
    chk(got.size() == 0 && acc_n == 0, "R8", "stray bytes activity",
        got.size() + acc_n, 0);

    // R10 back-pressure with stalled response
    clear_logs();
    stall_tx = 1'b1;
    send_byte(8'h55); send_byte(8'h10); send_byte(8'h00);
    send_byte(8'h05); send_byte(8'hAA);
    repeat (20) @(negedge clk);
    chk(tx_valid && tx_data == 8'hAA, "R9", "stalled byte held",
        {tx_valid, tx_data}, 9'h1AA);
    send_byte(8'h55); send_byte(8'h11); send_byte(8'h00); send_byte(8'h07);
    rx_data = 8'h12; rx_valid = 1'b1;
    begin
      int hi = 0;
      repeat (6) begin @(negedge clk); if (rx_ready) hi++; end
      chk(hi == 0, "R10", "rx_ready with full queue", hi, 0);
    end
    stall_tx = 1'b0;
    send_byte(8'h12); send_byte(8'h34); send_byte(8'h56); send_byte(8'h78);
    send_byte(8'hAA);
    sh[7] = 32'h12345678;
    exp_q = {8'hAA, 8'h7F, 8'h05, 8'h05, 8'h05, 8'h05, 8'h55, 8'hAA, 8'h7E, 8'h55};
    wait_resp(exp_q.size());
    cmp_stream("R10");
    chk(acc_n == 2 && acc_wr && acc_addr == 16'h0007 && acc_wd == 32'h12345678,
        "R10", "buffered write", {acc_n[3:0], acc_addr, acc_wd}, {4'd2, 16'h0007, 32'h12345678});
    do_cmd(0, 16'h0007, '0, '0);            // R2 read-back of buffered write

    // random mix
    for (int k = 0; k < 60; k++) begin
      int kind;
      logic [15:0] a;
      int sel = $urandom % 10;
      kind = (sel < 4) ? 0 : (sel < 7) ? 1 : (sel == 7) ? 2 : (sel == 8) ? 3 : 4;
      a = (($urandom % 8) == 0) ? 16'h0100 + 16'($urandom % 512) : 16'($urandom % 256);
      op = 8'($urandom);
      if (kind == 3 && (op == 8'h01 || op == 8'h10 || op == 8'h11)) op = op ^ 8'h80;
      if (kind == 4 && op == 8'hAA) op = 8'hAB;
      do_cmd(kind, a, $urandom, op);
    end

    chk(hold_bad == 0, "R9", "tx held under stall", hold_bad, 0);
    summary();
    $finish;
  end
endmodule